// File: doc/BRIEF.md
# Page error-detection signature generator

This block computes a six-byte Reed-Solomon check value over a flash page of 512 data bytes as the bytes stream past, one byte per accepted clock. It works in both transfer directions. When a page is being written, the block produces the six check bytes so that the storage path can append them after the data. When a page is being read back, the six stored check bytes follow the data into the block, and it reports whether the page is free of errors. The six remainder bytes are exposed so that software can locate and repair errors; the hardware itself only detects them.

Bytes arrive on a simple stream made of a valid strobe, a page-start marker that accompanies the first byte, and the byte itself. The direction is sampled together with the page-start byte and holds for the whole page. A new page-start marker can arrive at any time. It drops whatever computation or output is in progress and begins a fresh page with that byte.

Top module: `rs_page_signer`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `done` are low until a page completes, and `syndrome` reads zero.
- R2: In write mode (`rd_mode` = 0 on the page-start byte) the check value is the remainder of m(x)·x^6 divided by g(x) = (x+α^0)(x+α^1)…(x+α^5) over GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1 (0x11D), α = 0x02, and the first data byte is the highest-degree coefficient of m(x).
- R3: In write mode the six check bytes leave on `out_data` with `out_valid` high for six consecutive cycles, starting in the cycle after the 512th data byte is accepted, with the highest-degree coefficient first.
- R4: In read mode (`rd_mode` = 1 on the page-start byte) the block takes 518 bytes, the data followed by the check bytes in emission order. A page whose bytes are an unaltered codeword ends with `err` = 0 and `syndrome` all zero.
- R5: In read mode `syndrome` at `done` equals the remainder of r(x)·x^6 divided by g(x), where r(x) is the 518 received bytes, first byte highest. `err` is 1 exactly when this value is nonzero. `err` is always 0 at the end of a write page.
- R6: `done` is high for exactly one cycle, the cycle after the final byte (the 512th in write mode, the 518th in read mode). `err` and `syndrome` are valid in that same cycle, and in write mode `syndrome` then holds the six check bytes with the highest-degree coefficient in bits [47:40].
- R7: Cycles with `in_valid` low change neither the page position nor the running remainder.
- R8: A byte with `in_valid` and `in_first` high always starts a new page at that byte. This holds in mid-page and also while check bytes are still being emitted, in which case the emission stops from the next cycle on.
- R9: Changes of `rd_mode` after the page-start byte have no effect until the next page start.
- R10: Bytes with `in_valid` high and `in_first` low that arrive after a page has completed, including during check-byte emission, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present this cycle |
| in_first | input | 1 | Marks the first byte of a page (valid only with `in_valid`) |
| in_data | input | 8 | Input byte |
| rd_mode | input | 1 | 0 = generate check bytes, 1 = check a received page; sampled with the page-start byte |
| out_valid | output | 1 | A check byte is on `out_data` (write mode) |
| out_data | output | 8 | Check byte, highest-degree coefficient first |
| done | output | 1 | One-cycle pulse after the final byte of a page |
| err | output | 1 | Read page failed the check (valid with `done`) |
| syndrome | output | 8*NPAR | Remainder bytes, highest degree in the top byte (valid with `done`) |

## Verification
The corner cases the bench goes after are the following:
- Corrupting a single data byte, and separately only one stored check byte. A design that skipped the check bytes in its count, or compared too early, would miss the second case.
- Starting a new page partway through a page and again two cycles into check-byte emission. A design that failed to clear its remainder or its emission counter would produce wrong check bytes or emit stale bytes over the new page.
- Random stalls and toggling of `rd_mode` within a page. A design that advanced on idle cycles or re-sampled the direction would finish at the wrong byte count or in the wrong mode.
- Trailing bytes without a start marker after completion. A design that still accepted them would corrupt the emitted check bytes or raise a spurious `done`.

// File: rtl/rs_page_signer.sv
module rs_page_signer #(
  parameter int         PAGE_BYTES = 512,
  parameter int         NPAR       = 6,
  parameter logic [8:0] FIELD_POLY = 9'h11D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [7:0]        in_data,
  input  logic              rd_mode,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              done,
  output logic              err,
  output logic [8*NPAR-1:0] syndrome
);

  localparam int RW     = 8 * NPAR;
  localparam int RD_LEN = PAGE_BYTES + NPAR;
  localparam int CW     = $clog2(RD_LEN + 1);
  localparam int EW     = $clog2(NPAR + 1);
  localparam logic [CW-1:0] END_WR = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] END_RD = CW'(RD_LEN);

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ FIELD_POLY[7:0]) : (x << 1);
    end
    return p;
  endfunction

  // low coefficients g_{NPAR-1}..g_0 of the monic generator, byte j = g_j
  function automatic logic [RW-1:0] gen_coefs();
    logic [RW+7:0] c;
    logic [7:0]    r;
    c      = '0;
    c[7:0] = 8'h01;
    r      = 8'h01;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = i + 1; j >= 1; j--)
        c[8*j +: 8] = c[8*(j-1) +: 8] ^ gf_mul(c[8*j +: 8], r);
      c[7:0] = gf_mul(c[7:0], r);
      r      = gf_mul(r, 8'h02);
    end
    return c[RW-1:0];
  endfunction

  localparam logic [RW-1:0] GEN = gen_coefs();

  function automatic logic [RW-1:0] lfsr_step(input logic [RW-1:0] r, input logic [7:0] d);
    logic [7:0]    fb;
    logic [RW-1:0] n;
    fb = d ^ r[RW-1 -: 8];
    n  = r << 8;
    for (int j = 0; j < NPAR; j++)
      n[8*j +: 8] = n[8*j +: 8] ^ gf_mul(GEN[8*j +: 8], fb);
    return n;
  endfunction

  logic [RW-1:0] rem;
  logic [CW-1:0] cnt;
  logic          busy;
  logic          mode_q;
  logic [EW-1:0] emit;
  logic          done_q;
  logic          err_q;

  wire           start    = in_valid & in_first;
  wire           take     = in_valid & busy & ~in_first;
  wire           cur_mode = start ? rd_mode : mode_q;
  wire [RW-1:0]  nxt      = lfsr_step(start ? '0 : rem, in_data);
  wire [CW-1:0]  cnt_n    = (start ? '0 : cnt) + 1'b1;
  wire           last     = (start | take) && (cnt_n == (cur_mode ? END_RD : END_WR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      mode_q <= 1'b0;
      emit   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start | take) begin
        rem    <= nxt;
        cnt    <= cnt_n;
        mode_q <= cur_mode;
        busy   <= ~last;
        emit   <= (last && !cur_mode) ? EW'(NPAR) : '0;
        if (last) begin
          done_q <= 1'b1;
          err_q  <= cur_mode && (nxt != '0);
        end else if (start) begin
          err_q  <= 1'b0;
        end
      end else if (emit != '0) begin
        rem  <= rem << 8;
        emit <= emit - 1'b1;
      end
    end
  end

  assign out_valid = (emit != '0);
  assign out_data  = rem[RW-1 -: 8];
  assign done      = done_q;
  assign err       = err_q;
  assign syndrome  = rem;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_emit_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_write_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> !err);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> (!out_valid && !done));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_valid && in_first)) |=> $stable(mode_q));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_valid) |=> ($stable(rem) && $stable(cnt)));

  assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_first) && emit == '0) |=> ($stable(rem) && !done));

endmodule

// File: tb/sim_rs_page_signer.sv
`timescale 1ns/1ps
module sim_rs_page_signer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, rd_mode = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid, done, err;
  logic [7:0]  out_data;
  logic [47:0] syndrome;

  always #10 clk = ~clk;

  rs_page_signer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .rd_mode(rd_mode), .out_valid(out_valid),
    .out_data(out_data), .done(done), .err(err), .syndrome(syndrome)
  );

  int    cyc = 0;
  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    mon_on = 1'b0;
  logic [7:0]  gp [7];
  logic [7:0]  pg [$];
  logic [7:0]  dq [$];
  bit          pg_act = 1'b0, pg_mode = 1'b0;
  logic [7:0]  exp_byte [int];
  bit          exp_done [int];
  bit          exp_err  [int];
  logic [47:0] exp_syn  [int];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    int acc = 0;
    int aa = a;
    int bb = b;
    while (bb != 0) begin
      if (bb & 1) acc = acc ^ aa;
      aa = aa << 1;
      if (aa & 256) aa = aa ^ 'h11D;
      bb = bb >> 1;
    end
    return acc[7:0];
  endfunction

  function automatic logic [47:0] ref_rem(input logic [7:0] q [$]);
    logic [7:0]  a [$];
    logic [47:0] r = '0;
    int          n = q.size();
    a = q;
    repeat (6) a.push_back(8'h00);
    for (int i = 0; i < n; i++) begin
      logic [7:0] c = a[i];
      for (int j = 1; j <= 6; j++) a[i+j] = a[i+j] ^ gm(c, gp[j]);
    end
    for (int j = 0; j < 6; j++) r = (r << 8) | 48'(a[n+j]);
    return r;
  endfunction

  function automatic void check(bit ok, string what, logic [63:0] act, logic [63:0] ex);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, ex);
    end
  endfunction

  function automatic void model_update(bit f, logic [7:0] d, bit m);
    int k = cyc + 1;
    if (f) begin
      int drop [$];
      foreach (exp_byte[i]) if (i >= k) drop.push_back(i);
      foreach (drop[i]) exp_byte.delete(drop[i]);
      pg.delete();
      pg_act  = 1'b1;
      pg_mode = m;
    end
    if (pg_act) begin
      pg.push_back(d);
      if (pg.size() == (pg_mode ? 518 : 512)) begin
        logic [47:0] s = ref_rem(pg);
        pg_act      = 1'b0;
        exp_done[k] = 1'b1;
        exp_err[k]  = pg_mode && (s != '0);
        exp_syn[k]  = s;
        if (!pg_mode)
          for (int j = 0; j < 6; j++) exp_byte[k+j] = s[47-8*j -: 8];
      end
    end
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      int c;
      bit ev, ed;
      c  = cyc;
      ev = exp_byte.exists(c);
      ed = exp_done.exists(c);
      check(out_valid == ev, "out_valid", 64'(out_valid), 64'(ev));
      if (ev) check(out_data == exp_byte[c], "check byte", 64'(out_data), 64'(exp_byte[c]));
      check(done == ed, "done", 64'(done), 64'(ed));
      if (ed) begin
        check(err == exp_err[c], "err", 64'(err), 64'(exp_err[c]));
        check(syndrome == exp_syn[c], "syndrome", 64'(syndrome), 64'(exp_syn[c]));
      end
    end
  end

  task automatic push(bit f, logic [7:0] d, bit m);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_data = d; rd_mode = m;
    model_update(f, d, m);
  endtask

  task automatic idle(int n, bit m);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_data = 8'h5A; rd_mode = m;
    end
  endtask

  task automatic make_data(int seed, bit zero, bit rd);
    int s = seed;
    logic [47:0] p;
    dq.delete();
    for (int i = 0; i < 512; i++) begin
      s = s * 1103515245 + 12345;
      dq.push_back(zero ? 8'h00 : s[23:16]);
    end
    if (rd) begin
      p = ref_rem(dq);
      for (int j = 0; j < 6; j++) dq.push_back(p[47-8*j -: 8]);
    end
  endtask

  task automatic send(bit m, int gap, bit toggle, int limit);
    int n = (limit > 0) ? limit : dq.size();
    for (int i = 0; i < n; i++) begin
      bit mm = (toggle && (i % 2 == 1)) ? ~m : m;
      push(i == 0, dq[i], mm);
      if (gap > 0 && (i % gap) == gap - 1) idle(1 + i % 3, toggle ? ~m : m);
    end
  endtask

  initial begin
    gp[0] = 8'h01;
    for (int k = 1; k < 7; k++) gp[k] = 8'h00;
    begin
      logic [7:0] r = 8'h01;
      for (int i = 0; i < 6; i++) begin
        for (int k = i + 1; k >= 1; k--) gp[k] = gp[k] ^ gm(r, gp[k-1]);
        r = gm(r, 8'h02);
      end
    end

    cur_req = "R1";
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "out_valid in reset", 64'(out_valid), 0);
      check(done == 1'b0, "done in reset", 64'(done), 0);
      check(syndrome == '0, "syndrome in reset", 64'(syndrome), 0);
    end
    rst_n  = 1'b1;
    mon_on = 1'b1;
    idle(3, 1'b0);

    cur_req = "R2";
    make_data(0, 1'b1, 1'b0); send(1'b0, 0, 1'b0, 0); idle(10, 1'b0);
    make_data(11, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0); idle(10, 1'b0);

    cur_req = "R3";
    make_data(1, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0); idle(8, 1'b0);

    cur_req = "R4";
    make_data(1, 1'b0, 1'b1); send(1'b1, 0, 1'b0, 0); idle(4, 1'b1);

    cur_req = "R5";
    make_data(2, 1'b0, 1'b1); dq[100] = dq[100] ^ 8'h40; send(1'b1, 0, 1'b0, 0); idle(4, 1'b1);
    make_data(3, 1'b0, 1'b1); dq[515] = dq[515] ^ 8'h01; send(1'b1, 0, 1'b0, 0); idle(4, 1'b0);

    cur_req = "R6";
    make_data(4, 1'b0, 1'b1); send(1'b1, 0, 1'b0, 0); idle(1, 1'b0);
    make_data(4, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0); idle(8, 1'b0);

    cur_req = "R7";
    make_data(5, 1'b0, 1'b0); send(1'b0, 7, 1'b0, 0); idle(8, 1'b0);
    make_data(6, 1'b0, 1'b1); send(1'b1, 5, 1'b0, 0); idle(4, 1'b0);

    cur_req = "R8";
    make_data(7, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 200);
    make_data(8, 1'b0, 1'b1); send(1'b1, 0, 1'b0, 0);
    make_data(9, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0); idle(2, 1'b0);
    make_data(10, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0); idle(8, 1'b0);

    cur_req = "R9";
    make_data(12, 1'b0, 1'b0); send(1'b0, 9, 1'b1, 0); idle(8, 1'b0);
    make_data(13, 1'b0, 1'b1); send(1'b1, 9, 1'b1, 0); idle(4, 1'b0);

    cur_req = "R10";
    make_data(14, 1'b0, 1'b1); send(1'b1, 0, 1'b0, 0);
    for (int i = 0; i < 5; i++) push(1'b0, 8'(i * 37 + 1), 1'b0);
    idle(4, 1'b0);
    make_data(15, 1'b0, 1'b0); send(1'b0, 0, 1'b0, 0);
    for (int i = 0; i < 4; i++) push(1'b0, 8'(i * 91 + 3), 1'b1);
    idle(10, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule